// File: doc/BRIEF.md
# Dual-Channel Streaming Median-of-Three Filter

This block removes isolated spikes from two parallel streams of raw accumulator readings. Each stream has its own short history. When a sample arrives and filtering is enabled, the block outputs the median of that sample and the two raw samples that came before it on the same channel. It then pushes the new raw sample into that channel's history. Both channels share one valid strobe, one enable and one burst marker, so they always advance together.

A burst-start pulse reloads both histories with a seed pair: the newer slot gets all zeros and the older slot gets all ones. With that seed, the median of the first sample of a burst is the sample itself. Filtering can be switched off for a whole burst. The raw sample then goes straight to the output, and the history does not change until the next burst start reloads it. Every result is registered, so the output valid follows the input valid by exactly one clock. Scaling and packing of the results are done by logic downstream.

Top module: `dmf_top`

## Requirements
- R1: With `filt_en` high, a valid sample produces the median of {current raw sample, newer history slot, older history slot} of that channel. Ties resolve to the repeated value.
- R2: Channel A (`in_a`/`out_a`) and channel B (`in_b`/`out_b`) keep separate histories. One channel's data never affects the other channel's result.
- R3: `burst_start` loads the newer slot with 0 and the older slot with all ones. If `burst_start` and `in_valid` are high in the same cycle, the seeded history is used for that sample. The first filtered output of a burst therefore equals its input.
- R4: On a filtered valid sample, the newer slot takes the raw input and the older slot takes the previous newer value. The filtered result is never written into the history.
- R5: With `filt_en` low, a valid sample appears unchanged on the output.
- R6: The history changes only on a filtered valid sample or on `burst_start`. Bypassed samples and idle cycles leave it untouched.
- R7: `out_valid` is `in_valid` delayed by exactly one clock.
- R8: `out_a` and `out_b` keep their values in any cycle after one with `in_valid` low.
- R9: While `rst_n` is low, `out_valid` and both outputs are 0, and both histories hold the seed pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new sample pair is present |
| in_a | input | W | Raw sample, channel A |
| in_b | input | W | Raw sample, channel B |
| filt_en | input | 1 | 1 = median filter, 0 = pass through |
| burst_start | input | 1 | Reload both histories with the seed pair |
| out_valid | output | 1 | Result pair is present |
| out_a | output | W | Result, channel A |
| out_b | output | W | Result, channel B |

## Verification
The assertions assume that `in_valid`, `filt_en` and `burst_start` are held low through reset. They also assume these inputs settle before each rising edge, so that the `$past` values of the inputs are the samples the block actually took. The bench holds the controls at zero during reset. It changes inputs only on the falling edge. It applies `filt_en` and `burst_start` per cycle, mixed at random, so it covers combinations the assertions must tolerate: a burst start alone, a burst start together with a bypassed sample, and a gap in valid. The random data mixes full-range words, a narrow range that forces ties, and the extreme codes 0 and all ones.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int CH_COUNT = 2;

  typedef enum logic {
    PATH_BYPASS = 1'b0,
    PATH_MEDIAN = 1'b1
  } dmf_path_e;
endpackage

// File: rtl/dmf_hist.sv
module dmf_hist #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         filt_en,
  input  logic         burst_start,
  input  logic [W-1:0] raw,
  output logic [W-1:0] eff_new,
  output logic [W-1:0] eff_old,
  output logic [W-1:0] hist_new,
  output logic [W-1:0] hist_old
);
  localparam logic [W-1:0] SEED_NEW = '0;
  localparam logic [W-1:0] SEED_OLD = '1;

  logic shift_en;
  assign shift_en = in_valid & filt_en;

  // history as seen by the current sample: a burst start seeds it at once
  assign eff_new = burst_start ? SEED_NEW : hist_new;
  assign eff_old = burst_start ? SEED_OLD : hist_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_new <= SEED_NEW;
      hist_old <= SEED_OLD;
    end else if (shift_en) begin
      hist_new <= raw;
      hist_old <= eff_new;
    end else if (burst_start) begin
      hist_new <= SEED_NEW;
      hist_old <= SEED_OLD;
    end
  end
endmodule

// File: rtl/dmf_sel.sv
module dmf_sel #(
  parameter int W = 32
) (
  input  dmf_pkg::dmf_path_e path,
  input  logic [W-1:0]       raw,
  input  logic [W-1:0]       eff_new,
  input  logic [W-1:0]       eff_old,
  output logic [W-1:0]       result
);
  function automatic logic [W-1:0] lo2(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic [W-1:0] hi2(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x > y) ? x : y;
  endfunction

  // median = largest of the three pairwise minima
  function automatic logic [W-1:0] med3(input logic [W-1:0] p, input logic [W-1:0] q,
                                        input logic [W-1:0] r);
    return hi2(hi2(lo2(p, q), lo2(p, r)), lo2(q, r));
  endfunction

  always_comb begin
    if (path == dmf_pkg::PATH_MEDIAN) result = med3(raw, eff_new, eff_old);
    else                              result = raw;
  end
endmodule

// File: rtl/dmf_top.sv
module dmf_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         filt_en,
  input  logic         burst_start,
  output logic         out_valid,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);
  import dmf_pkg::*;
  localparam int CH = CH_COUNT;

  logic [W-1:0] raw      [CH];
  logic [W-1:0] eff_new  [CH];
  logic [W-1:0] eff_old  [CH];
  logic [W-1:0] hist_new [CH];
  logic [W-1:0] hist_old [CH];
  logic [W-1:0] result   [CH];
  logic [W-1:0] out_q    [CH];
  dmf_path_e    path;
  logic         valid_q;

  assign raw[0] = in_a;
  assign raw[1] = in_b;
  assign path   = filt_en ? PATH_MEDIAN : PATH_BYPASS;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    dmf_hist #(.W(W)) u_hist (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .filt_en(filt_en),
      .burst_start(burst_start), .raw(raw[c]), .eff_new(eff_new[c]),
      .eff_old(eff_old[c]), .hist_new(hist_new[c]), .hist_old(hist_old[c])
    );

    dmf_sel #(.W(W)) u_sel (
      .path(path), .raw(raw[c]), .eff_new(eff_new[c]),
      .eff_old(eff_old[c]), .result(result[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        out_q[c] <= '0;
      else if (in_valid) out_q[c] <= result[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end

  assign out_valid = valid_q;
  assign out_a     = out_q[0];
  assign out_b     = out_q[1];
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         filt_en,
  input logic         burst_start,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic [W-1:0] out_a,
  input logic [W-1:0] out_b,
  input logic [W-1:0] eff_new_a,
  input logic [W-1:0] eff_old_a,
  input logic [W-1:0] hist_new_a,
  input logic [W-1:0] hist_old_a,
  input logic [W-1:0] hist_new_b,
  input logic [W-1:0] hist_old_b
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !filt_en |=> out_a == $past(in_a) && out_b == $past(in_b)); // R5
  AST_SEED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && filt_en && burst_start |=> out_a == $past(in_a) && out_b == $past(in_b)); // R3
  AST_MEDIAN_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && filt_en |=> (out_a == $past(in_a) || out_a == $past(eff_new_a)
                             || out_a == $past(eff_old_a))); // R1
  AST_HIST_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && filt_en |=> hist_new_a == $past(in_a) && hist_old_a == $past(eff_new_a)
                            && hist_new_b == $past(in_b)); // R4
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_start && !(in_valid && filt_en) |=> $stable(hist_new_a) && $stable(hist_old_a)
                                               && $stable(hist_new_b) && $stable(hist_old_b)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_a) && $stable(out_b)); // R8
endmodule

bind dmf_top dmf_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .filt_en(filt_en),
  .burst_start(burst_start), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_a(out_a), .out_b(out_b), .eff_new_a(eff_new[0]), .eff_old_a(eff_old[0]),
  .hist_new_a(hist_new[0]), .hist_old_a(hist_old[0]),
  .hist_new_b(hist_new[1]), .hist_old_b(hist_old[1])
);

// File: tb/tb_dmf_top.sv
module tb_dmf_top;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, filt_en = 1'b0, burst_start = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [W-1:0] out_a, out_b;

  int tests = 0, fails = 0;
  logic [W-1:0] m_new [2], m_old [2], m_out [2];
  logic m_vld;

  always #2 clk = ~clk;

  dmf_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .filt_en(filt_en), .burst_start(burst_start), .out_valid(out_valid),
    .out_a(out_a), .out_b(out_b)
  );

  // median by case analysis on the ordering, not by pairwise minima
  function automatic logic [W-1:0] mid_of(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] c);
    if (a >= b) return (b >= c) ? b : ((a >= c) ? c : a);
    else        return (a >= c) ? a : ((b >= c) ? c : b);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic seed_model();
    for (int c = 0; c < 2; c++) begin m_new[c] = '0; m_old[c] = ONES; end
  endtask

  // drive one cycle at the falling edge, predict, check at the next falling edge
  task automatic step(input logic v, input logic en, input logic bs,
                      input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W-1:0] r [2];
    logic [W-1:0] en_new, en_old;
    r[0] = a; r[1] = b;
    in_valid = v; filt_en = en; burst_start = bs; in_a = a; in_b = b;
    for (int c = 0; c < 2; c++) begin
      en_new = bs ? '0 : m_new[c];
      en_old = bs ? ONES : m_old[c];
      if (v) m_out[c] = en ? mid_of(r[c], en_new, en_old) : r[c];
      if (v && en) begin m_old[c] = en_new; m_new[c] = r[c]; end
      else if (bs) begin m_new[c] = '0; m_old[c] = ONES; end
    end
    m_vld = v;
    @(negedge clk);
    chk({req, " R7 valid"}, W'(out_valid), W'(m_vld));
    chk({req, " R2 chA"}, out_a, m_out[0]);
    chk({req, " R2 chB"}, out_b, m_out[1]);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    seed_model();
    m_out[0] = '0; m_out[1] = '0; m_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", W'(out_valid), '0);
    chk("R9 reset outA", out_a, '0);
    chk("R9 reset outB", out_b, '0);
    rst_n = 1'b1;
    // R9: seed from reset gives identity on the very first sample
    step(1, 1, 0, 32'd77, 32'd3, "R9 first after reset");
    // R3: burst start with the sample
    step(1, 1, 1, 32'd5, 32'hFFFF_FFF0, "R3 seeded first");
    // R1: median sequence with ties, R4 raw history
    step(1, 1, 0, 32'd1, 32'd9, "R1 second");
    step(1, 1, 0, 32'd900, 32'd9, "R1 spike");
    step(1, 1, 0, 32'd6, 32'd9, "R4 raw history");
    step(0, 1, 0, 32'd1234, 32'd4321, "R8 idle hold");
    // R5, R6: bypass leaves history frozen
    step(1, 0, 0, 32'd0, ONES, "R5 bypass");
    step(1, 0, 0, 32'd50, 32'd60, "R5 bypass again");
    step(1, 1, 0, 32'd7, 32'd8, "R6 resume");
    // R3: burst start alone, no valid
    step(0, 1, 1, 32'd0, 32'd0, "R3 lone seed");
    step(1, 1, 0, 32'd42, 32'd43, "R3 after lone seed");
    step(1, 1, 0, ONES, 32'd0, "R1 extremes");
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      int mode;
      mode = $urandom_range(0, 3);
      a = $urandom(); b = $urandom();
      if (mode == 1) begin a = $urandom_range(0, 3); b = $urandom_range(0, 3); end
      if (mode == 2) begin a = ($urandom_range(0, 1) != 0) ? ONES : '0; b = ~a; end
      step($urandom_range(0, 4) != 0, $urandom_range(0, 5) != 0,
           $urandom_range(0, 15) == 0, a, b, "R1 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule